// File: doc/BRIEF.md
# Sequential Shift-and-Add Unsigned Multiplier

This block multiplies two unsigned operands of equal width (32 bits by default) and returns a product twice that width. It does one conditional add and one right shift per clock. A working register twice the operand width holds the growing partial product in its upper half. The multiplier bits not yet consumed sit in its lower half. A request is accepted with a single-cycle `start` while the block is idle. `busy` stays high for exactly one cycle per operand bit. A one-cycle `done` then marks the product as valid. The product stays on the output until the next accepted request.

Each step adds into the upper half when the lowest bit of the working register is set. The adder is a carry-lookahead adder with a carry-in of zero. Every bit forms a propagate term (XOR of the operand bits) and a generate term (AND). Carries are resolved in parallel inside fixed-size groups, and the group carries ripple from one group to the next. After each step the register moves right by one place and its lowest bit is lost. The carry out of the add enters at the top, so no product bit is dropped when the upper half overflows.

Top module: `shiftadd_mult`

## Requirements
- R1: While `rst` is sampled high at a rising clock edge, the block clears itself. After that edge, `busy` is 0, `done` is 0 and `product` is 0.
- R2: A `start` sampled high while `busy` is 0 is accepted. `busy` is 1 in the next cycle. `op_b` is loaded as the multiplier into the lower half of the working register, the upper half is cleared, and `op_a` is captured as the multiplicand.
- R3: After an accepted `start`, `busy` stays high for exactly OPW (32) cycles. `done` rises in the cycle in which `busy` falls and is high for exactly one cycle. `done` is never high while `busy` is high.
- R4: When `done` is high, `product` equals the unsigned product of the `op_a` and `op_b` values sampled with the accepted `start`, as a 64-bit value.
- R5: The carry out of each add step is kept as the new top bit of the working register. With both operands all ones, the product is 0xFFFFFFFE00000001.
- R6: A `start` sampled while `busy` is 1 is ignored. Operand changes during a run are also ignored. The running operation completes on its original schedule with its original result.
- R7: While idle with no new request, `product` holds its last value, whatever happens on `op_a` and `op_b`.
- R8: If either operand is zero, the product is zero. This holds even when the other operand has all bits set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request pulse, accepted only while idle |
| op_a | input | 32 | Multiplicand (OPW bits) |
| op_b | input | 32 | Multiplier (OPW bits) |
| busy | output | 1 | High while the add-and-shift steps run |
| done | output | 1 | One-cycle pulse when the product becomes valid |
| product | output | 64 | Unsigned product (2*OPW bits) |

## Verification
The main function is tried with several kinds of input:
- Zero operands, against each other and against all ones. These show whether any step adds when no multiplier bit is set.
- A multiplier of one. This shows whether the multiplicand lands in the right place after all the shifts.
- Single high bits. These show whether the shift count is exact.
- Alternating bit patterns. These tell apart a wrong group carry from a wrong carry inside a group.
- All ones against all ones. Here the upper half overflows on almost every step, so the carry out must be kept as the top bit.
- A series of pseudo-random pairs.

Separate runs inject a second request and new operand values partway through a run, change the operands while idle, and reset in the middle of a run.

// File: rtl/shmul_pkg.sv
package shmul_pkg;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } phase_e;

    // Bits needed to count the steps 0 .. n-1.
    function automatic int unsigned step_bits(int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/cla_group.sv
// One lookahead group. Every carry inside the group is formed directly
// from the generate/propagate terms and the group carry-in.
module cla_group #(
    parameter int GW = 4
) (
    input  logic [GW-1:0] a,
    input  logic [GW-1:0] b,
    input  logic          cin,
    output logic [GW-1:0] sum,
    output logic          cout
);
    logic [GW-1:0] prop;
    logic [GW-1:0] gen;
    logic [GW:0]   cy;
    logic          chain;

    always_comb begin
        prop  = a ^ b;
        gen   = a & b;
        cy    = '0;
        chain = 1'b1;
        cy[0] = cin;
        for (int k = 1; k <= GW; k++) begin
            chain = 1'b1;
            for (int j = k - 1; j >= 0; j--) begin
                cy[k] = cy[k] | (gen[j] & chain);
                chain = chain & prop[j];
            end
            cy[k] = cy[k] | (chain & cin);
        end
        sum  = prop ^ cy[GW-1:0];
        cout = cy[GW];
    end
endmodule

// File: rtl/cla_adder.sv
// Lookahead groups of GW bits; group carries ripple between groups.
module cla_adder #(
    parameter int W  = 32,
    parameter int GW = 4
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout
);
    localparam int NGRP = W / GW;

    logic [NGRP:0] gcy;

    assign gcy[0] = cin;

    for (genvar gi = 0; gi < NGRP; gi++) begin : g_grp
        cla_group #(.GW(GW)) u_grp (
            .a    (a[gi*GW +: GW]),
            .b    (b[gi*GW +: GW]),
            .cin  (gcy[gi]),
            .sum  (sum[gi*GW +: GW]),
            .cout (gcy[gi+1])
        );
    end

    assign cout = gcy[NGRP];
endmodule

// File: rtl/mul_step.sv
// One add-and-shift step on the double-width working register.
module mul_step #(
    parameter int OPW = 32,
    parameter int GW  = 4
) (
    input  logic [2*OPW-1:0] acc,
    input  logic [OPW-1:0]   mcand,
    output logic [2*OPW-1:0] acc_nx
);
    logic [OPW-1:0] add_sum;
    logic           add_cy;

    cla_adder #(.W(OPW), .GW(GW)) u_add (
        .a    (acc[2*OPW-1:OPW]),
        .b    (mcand),
        .cin  (1'b0),
        .sum  (add_sum),
        .cout (add_cy)
    );

    always_comb begin
        if (acc[0]) begin
            acc_nx = {add_cy, add_sum, acc[OPW-1:1]};
        end else begin
            acc_nx = {1'b0, acc[2*OPW-1:1]};
        end
    end
endmodule

// File: rtl/shiftadd_mult.sv
module shiftadd_mult
    import shmul_pkg::*;
#(
    parameter int OPW = 32,
    parameter int GW  = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [OPW-1:0]   op_a,
    input  logic [OPW-1:0]   op_b,
    output logic             busy,
    output logic             done,
    output logic [2*OPW-1:0] product
);
    localparam int          CW        = step_bits(OPW);
    localparam logic [CW-1:0] LAST_STEP = CW'(OPW - 1);

    typedef struct packed {
        phase_e           phase;
        logic [CW-1:0]    step;
        logic [2*OPW-1:0] acc;
        logic [OPW-1:0]   mcand;
        logic             done;
    } mul_st_t;

    localparam mul_st_t ST_RESET = '{
        phase: PH_IDLE,
        step:  '0,
        acc:   '0,
        mcand: '0,
        done:  1'b0
    };

    mul_st_t          st_d, st_q;
    logic [2*OPW-1:0] acc_step_d;

    mul_step #(.OPW(OPW), .GW(GW)) u_step (
        .acc    (st_q.acc),
        .mcand  (st_q.mcand),
        .acc_nx (acc_step_d)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        unique case (st_q.phase)
            PH_IDLE: begin
                if (start) begin
                    st_d.acc   = {{OPW{1'b0}}, op_b};
                    st_d.mcand = op_a;
                    st_d.step  = '0;
                    st_d.phase = PH_RUN;
                end
            end
            PH_RUN: begin
                st_d.acc = acc_step_d;
                if (st_q.step == LAST_STEP) begin
                    st_d.phase = PH_IDLE;
                    st_d.done  = 1'b1;
                end else begin
                    st_d.step = st_q.step + CW'(1);
                end
            end
            default: st_d = ST_RESET;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= ST_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy    = (st_q.phase == PH_RUN);
    assign done    = st_q.done;
    assign product = st_q.acc;
endmodule

// File: rtl/shiftadd_mult_chk.sv
module shiftadd_mult_chk #(
    parameter int OPW = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic [OPW-1:0]   op_a,
    input logic [OPW-1:0]   op_b,
    input logic             busy,
    input logic             done,
    input logic [2*OPW-1:0] product
);
    logic [15:0]      run_len;
    logic [2*OPW-1:0] exp_prod;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_len  <= '0;
            exp_prod <= '0;
        end else if (start && !busy) begin
            run_len  <= '0;
            exp_prod <= {{OPW{1'b0}}, op_a} * {{OPW{1'b0}}, op_b};
        end else if (busy) begin
            run_len  <= run_len + 16'd1;
        end
    end

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (!busy && !done && product == '0));

    assert_start_accept_R2: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

    assert_run_length_R3: assert property (@(posedge clk) disable iff (rst)
        ($fell(busy) && !$past(rst)) |-> (run_len == 16'(OPW)));

    assert_done_at_end_R3: assert property (@(posedge clk) disable iff (rst)
        ($fell(busy) && !$past(rst)) |-> done);

    assert_done_single_R3: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_not_busy_R3: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    assert_product_R4: assert property (@(posedge clk) disable iff (rst)
        done |-> (product == exp_prod));

    assert_busy_ignores_start_R6: assert property (@(posedge clk) disable iff (rst)
        (busy && start && run_len < 16'(OPW - 1)) |=> busy);

    assert_product_held_R7: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> $stable(product));
endmodule

bind shiftadd_mult shiftadd_mult_chk #(.OPW(OPW)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .op_a    (op_a),
    .op_b    (op_b),
    .busy    (busy),
    .done    (done),
    .product (product)
);

// File: tb/tb_shiftadd_mult.sv
module tb_shiftadd_mult;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [31:0] op_a = '0;
    logic [31:0] op_b = '0;
    logic        busy;
    logic        done;
    logic [63:0] product;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic [31:0] a;
        logic [31:0] b;
        logic [63:0] p;
        string       tag;
    } sb_item_t;

    sb_item_t sbq[$];

    always #5 clk = ~clk;

    shiftadd_mult dut (
        .clk(clk), .rst(rst), .start(start), .op_a(op_a), .op_b(op_b),
        .busy(busy), .done(done), .product(product)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] xs(input logic [31:0] x);
        logic [31:0] y;
        y = x ^ (x << 13);
        y = y ^ (y >> 17);
        y = y ^ (y << 5);
        return y;
    endfunction

    // Monitor: compares each completed product against the scoreboard.
    always @(negedge clk) begin
        if (!rst && done) begin
            if (sbq.size() == 0) begin
                check(1'b0, "R4", "done without request", product, 64'd0);
            end else begin
                sb_item_t it;
                it = sbq.pop_front();
                check(product === it.p, it.tag, "product", product, it.p);
            end
        end
    end

    // Driver: one request; optionally pokes start and new operands mid-run (R6).
    task automatic run_mult(input logic [31:0] a, input logic [31:0] b,
                            input string tag, input bit poke);
        sb_item_t it;
        bit early;
        it.a = a; it.b = b; it.tag = tag;
        it.p = {32'd0, a} * {32'd0, b};
        sbq.push_back(it);
        @(negedge clk);
        op_a = a; op_b = b; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy === 1'b1, "R2", "busy after start", 64'(busy), 64'd1);
        early = 1'b0;
        for (int n = 2; n <= 33; n++) begin
            @(negedge clk);
            if (poke && n == 10) begin
                start = 1'b1; op_a = ~a; op_b = b ^ 32'h5A5A_0F0F;
            end else begin
                start = 1'b0;
            end
            if (poke && n == 12) begin
                op_a = 32'h1234_5678;
            end
            if (n < 33 && (done || !busy)) early = 1'b1;
        end
        check(!early, poke ? "R6" : "R3", "busy held for 32 cycles", 64'(early), 64'd0);
        check(done === 1'b1 && busy === 1'b0, "R3", "done at cycle 33",
              {62'd0, busy, done}, 64'd1);
        @(negedge clk);
        check(done === 1'b0, "R3", "done single pulse", 64'(done), 64'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R3 watchdog expired: actual no completion expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] ra, rb;
        // R1: reset state
        repeat (3) @(negedge clk);
        check(busy === 1'b0 && done === 1'b0 && product === 64'd0, "R1",
              "reset outputs", product, 64'd0);
        rst = 1'b0;

        // R8: zero operands
        run_mult(32'd0, 32'hFFFF_FFFF, "R8", 1'b0);
        run_mult(32'hFFFF_FFFF, 32'd0, "R8", 1'b0);
        // R4: main function, assorted patterns
        run_mult(32'hDEAD_BEEF, 32'd1, "R4", 1'b0);
        run_mult(32'h8000_0000, 32'd2, "R4", 1'b0);
        run_mult(32'hAAAA_AAAA, 32'h5555_5555, "R4", 1'b0);
        run_mult(32'h0000_000F, 32'h8000_0001, "R4", 1'b0);
        // R5: carry out kept as new top bit
        run_mult(32'hFFFF_FFFF, 32'hFFFF_FFFF, "R5", 1'b0);
        // R6: start and operand changes ignored while busy
        run_mult(32'h0F0F_1234, 32'hC001_D00D, "R6", 1'b1);

        // R7: product held while idle, operands toggling
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            op_a = xs(32'h1357_9BDF + k); op_b = ~op_a;
            check(product === 64'h0F0F_1234 * 64'hC001_D00D, "R7", "product held",
                  product, 64'h0F0F_1234 * 64'hC001_D00D);
        end

        ra = 32'h2545_F491; rb = 32'h9E37_79B9;
        for (int k = 0; k < 8; k++) begin
            ra = xs(ra); rb = xs(rb ^ ra);
            run_mult(ra, rb, "R4", 1'b0);
        end

        // R1: reset in the middle of a run
        @(negedge clk);
        op_a = 32'h7777_7777; op_b = 32'h3333_3333; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (7) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check(busy === 1'b0 && done === 1'b0 && product === 64'd0, "R1",
              "mid-run reset", product, 64'd0);
        repeat (40) @(negedge clk);
        check(done === 1'b0 && busy === 1'b0, "R1", "no completion after reset",
              {62'd0, busy, done}, 64'd0);
        run_mult(32'h0001_0001, 32'hFFFF_0000, "R4", 1'b0);

        repeat (3) @(negedge clk);
        check(sbq.size() == 0, "R4", "scoreboard drained", 64'(sbq.size()), 64'd0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule